// File: doc/BRIEF.md
# Programmable Scaler Gate Combiner

This block turns a 32-bit word of control inputs into one gate bit that qualifies a bank of counters on every crossing clock. The inputs fall into four 8-bit groups. Groups 0 and 1 are AND-type and groups 2 and 3 are OR-type. Each group has its own mask that picks which inputs take part, a polarity bit that inverts the group result, and an enable. A final stage ANDs the results of the enabled groups, can invert that AND, and is held low by a global enable.

The groups do not all sample their inputs the same way. Groups 0, 1 and 3 use the value that was registered at the last rising clock edge. Group 2 uses the live input. Input 31 is a special case: it is the OR of its registered copy and its live copy. The registered 32-bit word is also brought out on a monitor port so that software can read it back as two 16-bit halves.

Configuration arrives on plain input ports. Address decoding is done elsewhere.

Top module: `scaler_gate_combiner`

## Requirements
- R1: Groups 0 and 1 (inputs 7:0 and 15:8) output the AND of their masked inputs. When the polarity bit is set, they output the NAND instead. Inputs outside the mask have no effect.
- R2: Groups 2 and 3 (inputs 23:16 and 31:24) output the OR of their masked inputs. When the polarity bit is set, they output the NOR instead.
- R3: When a group's mask is all zero, the group outputs its empty default. An AND-type group outputs 1, or 0 with the polarity bit set. An OR-type group outputs 0, or 1 with the polarity bit set.
- R4: A group whose enable bit is 0 is left out of the final combination, whatever its mask, polarity and inputs are.
- R5: The gate is the AND of the results of all enabled groups. It is the NAND of those results when `comb_invert` is 1.
- R6: While `comb_global_en` is 0, `gate_out` is 0.
- R7: With all four groups disabled, `comb_global_en` at 1 and `comb_invert` at 0, `gate_out` is 1 for any input.
- R8: Groups 0, 1 and 3 use the input value registered at the last rising clock edge. Group 2 uses the current value of `ctl_in` without any register.
- R9: Input 31 is the OR of its registered copy and its current value. No other input of group 3 gets this treatment.
- R10: `mon_q` holds the value of `ctl_in` registered at the last rising edge. Synchronous reset clears it to 0. A change on `ctl_in` between edges does not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_in | input | 32 | Control inputs; group g uses bits 8g+7:8g |
| grp_cfg | input | 40 | Ten bits per group, group g at bits 10g+9:10g. Within a group: bits 7:0 are the mask, bit 8 is the polarity bit, bit 9 is the enable |
| comb_invert | input | 1 | 1 makes the final stage a NAND |
| comb_global_en | input | 1 | 0 holds the gate low |
| gate_out | output | 1 | Combined scaler gate |
| mon_q | output | 32 | Registered control inputs, for readback |

## Verification
The assertions sample combinational group results at the rising edge. They therefore assume that `ctl_in`, `grp_cfg` and the combine bits are stable around that edge. The bench meets this by changing every input on the falling edge only.

The bench changes group 2 inputs and input 31 between edges, so that their unregistered paths are seen apart from the registered ones. It reads each such result before the next rising edge, while the registered copy still holds the older value.

// File: rtl/gcl_pkg.sv
package gcl_pkg;

  typedef enum logic {GK_AND = 1'b0, GK_OR = 1'b1} grp_kind_e;

  // Group result: AND-type groups need every masked bit high,
  // OR-type groups need any masked bit high; polarity flips it.
  function automatic logic grp_result(grp_kind_e kind, logic pol,
                                      logic all_hi, logic any_hi);
    logic base;
    base = (kind == GK_AND) ? all_hi : any_hi;
    return base ^ pol;
  endfunction

  // Final combine: AND of contributions, optionally inverted, gated.
  function automatic logic final_gate(logic all_contrib, logic inv, logic glob);
    return glob & (all_contrib ^ inv);
  endfunction

endpackage

// File: rtl/gcl_input_stage.sv
module gcl_input_stage #(
  parameter int unsigned GRP_W      = 8,
  parameter int unsigned NUM_GRP    = 4,
  parameter logic [NUM_GRP-1:0] RAW_GROUPS = 4'b0100,
  parameter int unsigned BLEND_BIT  = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GRP*GRP_W-1:0]   ctl_in,
  output logic [NUM_GRP*GRP_W-1:0]   in_q,
  output logic [NUM_GRP*GRP_W-1:0]   eff
);
  localparam int unsigned N = NUM_GRP * GRP_W;

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= ctl_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (RAW_GROUPS[i / GRP_W]) begin : g_raw
      assign eff[i] = ctl_in[i];
    end else if (i == BLEND_BIT) begin : g_blend
      assign eff[i] = in_q[i] | ctl_in[i];
    end else begin : g_reg
      assign eff[i] = in_q[i];
    end
  end

  // R10: registered copy follows the input one edge later
  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (in_q == $past(ctl_in)));

  // R9: a high blend input seen at the last edge keeps its path high
  p_blend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctl_in[BLEND_BIT])) |-> eff[BLEND_BIT]);

endmodule

// File: rtl/gcl_group_unit.sv
module gcl_group_unit
  import gcl_pkg::*;
#(
  parameter int unsigned GRP_W = 8,
  parameter grp_kind_e   KIND  = GK_AND
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] data,
  input  logic [GRP_W-1:0] mask,
  input  logic             pol,
  input  logic             en,
  output logic             contrib
);
  logic all_hi, any_hi, res;

  assign all_hi  = &(data | ~mask);
  assign any_hi  = |(data & mask);
  assign res     = grp_result(KIND, pol, all_hi, any_hi);
  assign contrib = en ? res : 1'b1;

  // R3: empty mask yields the kind-specific default
  p_empty_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mask == '0) |-> (contrib == ((KIND == GK_OR) ? pol : ~pol)));

  // R4: a disabled group never pulls the combination low
  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> contrib);

endmodule

// File: rtl/gcl_final_stage.sv
module gcl_final_stage
  import gcl_pkg::*;
#(
  parameter int unsigned NUM_GRP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] contrib,
  input  logic [NUM_GRP-1:0] en_vec,
  input  logic               invert,
  input  logic               glob,
  output logic               gate
);
  assign gate = final_gate(&contrib, invert, glob);

  // R6: global enable low holds the gate low
  p_global_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !glob |-> !gate);

  // R7: nothing enabled, no inversion -> gate high
  p_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (glob && en_vec == '0 && !invert) |-> gate);

endmodule

// File: rtl/scaler_gate_combiner.sv
module scaler_gate_combiner
  import gcl_pkg::*;
#(
  parameter int unsigned GRP_W      = 8,
  parameter int unsigned NUM_GRP    = 4,
  parameter logic [NUM_GRP-1:0] OR_GROUPS  = 4'b1100,
  parameter logic [NUM_GRP-1:0] RAW_GROUPS = 4'b0100,
  parameter int unsigned BLEND_BIT  = 31
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_GRP*GRP_W-1:0]         ctl_in,
  input  logic [NUM_GRP*(GRP_W+2)-1:0]     grp_cfg,
  input  logic                             comb_invert,
  input  logic                             comb_global_en,
  output logic                             gate_out,
  output logic [NUM_GRP*GRP_W-1:0]         mon_q
);
  localparam int unsigned N     = NUM_GRP * GRP_W;
  localparam int unsigned CFG_W = GRP_W + 2;

  logic [N-1:0]       in_q;
  logic [N-1:0]       eff;
  logic [NUM_GRP-1:0] contrib;
  logic [NUM_GRP-1:0] en_vec;

  gcl_input_stage #(
    .GRP_W(GRP_W), .NUM_GRP(NUM_GRP),
    .RAW_GROUPS(RAW_GROUPS), .BLEND_BIT(BLEND_BIT)
  ) u_in (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .in_q(in_q), .eff(eff)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam grp_kind_e KIND = OR_GROUPS[g] ? GK_OR : GK_AND;
    logic [CFG_W-1:0] cfg;
    assign cfg       = grp_cfg[g*CFG_W +: CFG_W];
    assign en_vec[g] = cfg[GRP_W+1];

    gcl_group_unit #(.GRP_W(GRP_W), .KIND(KIND)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .data(eff[g*GRP_W +: GRP_W]),
      .mask(cfg[GRP_W-1:0]),
      .pol(cfg[GRP_W]),
      .en(cfg[GRP_W+1]),
      .contrib(contrib[g])
    );
  end

  gcl_final_stage #(.NUM_GRP(NUM_GRP)) u_fin (
    .clk(clk), .rst_n(rst_n), .contrib(contrib), .en_vec(en_vec),
    .invert(comb_invert), .glob(comb_global_en), .gate(gate_out)
  );

  assign mon_q = in_q;

endmodule

// File: tb/scaler_gate_combiner_tb_top.sv
`timescale 1ns/1ps
module scaler_gate_combiner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctl_in = '0;
  logic [39:0] grp_cfg = '0;
  logic        comb_invert = 1'b0;
  logic        comb_global_en = 1'b0;
  logic        gate_out;
  logic [31:0] mon_q;
  logic [31:0] ref_q;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) ref_q <= rst_n ? ctl_in : 32'h0;

  scaler_gate_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .grp_cfg(grp_cfg),
    .comb_invert(comb_invert), .comb_global_en(comb_global_en),
    .gate_out(gate_out), .mon_q(mon_q)
  );

  function automatic logic [9:0] gc(logic en, logic pol, logic [7:0] m);
    return {en, pol, m};
  endfunction

  // independent model: walk each group bit by bit
  function automatic logic model(logic [31:0] rq, logic [31:0] raw,
                                 logic [39:0] cfg, logic inv, logic ge);
    logic acc;
    acc = 1'b1;
    for (int g = 0; g < 4; g++) begin
      logic [9:0] c;
      logic r;
      c = cfg[g*10 +: 10];
      r = (g < 2) ? 1'b1 : 1'b0;
      for (int b = 0; b < 8; b++) begin
        int k;
        logic v;
        k = g*8 + b;
        v = (g == 2) ? raw[k] : ((k == 31) ? (rq[k] | raw[k]) : rq[k]);
        if (c[b]) r = (g < 2) ? (r & v) : (r | v);
      end
      if (c[8]) r = ~r;
      if (c[9]) acc = acc & r;
    end
    if (!ge) return 1'b0;
    return inv ? ~acc : acc;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic setup(logic [39:0] cfg, logic inv, logic ge);
    @(negedge clk);
    grp_cfg = cfg; comb_invert = inv; comb_global_en = ge;
  endtask

  // set input, let one rising edge register it, sample at next falling edge
  task automatic drive(logic [31:0] d);
    @(negedge clk); ctl_in = d;
    @(negedge clk);
  endtask

  // change input between edges only
  task automatic poke(logic [31:0] d);
    ctl_in = d; #0.5;
  endtask

  task automatic t_reset();
    check("R10 reset mon", mon_q, 32'h0);
    check("R6 reset gate", {31'h0, gate_out}, 32'h0);
  endtask

  task automatic t_and_groups();
    setup({30'h0, gc(1, 0, 8'h0F)}, 0, 1);
    drive(32'h0000_000F); check("R1 and all", {31'h0, gate_out}, 1);
    drive(32'h0000_000E); check("R1 and one low", {31'h0, gate_out}, 0);
    drive(32'h0000_0007); check("R1 and bit3 low", {31'h0, gate_out}, 0);
    drive(32'h0000_002F); check("R1 unmasked ignored", {31'h0, gate_out}, 1);
    setup({30'h0, gc(1, 1, 8'h0F)}, 0, 1);
    drive(32'h0000_000F); check("R1 nand all", {31'h0, gate_out}, 0);
    drive(32'h0000_000E); check("R1 nand one low", {31'h0, gate_out}, 1);
    setup({20'h0, gc(1, 0, 8'hFF), 10'h0}, 0, 1);
    drive(32'h0000_FF00); check("R1 g1 all", {31'h0, gate_out}, 1);
    drive(32'h0000_7F00); check("R1 g1 one low", {31'h0, gate_out}, 0);
  endtask

  task automatic t_or_groups();
    setup({10'h0, gc(1, 0, 8'h03), 20'h0}, 0, 1);
    drive(32'h0000_0000); check("R2 or none", {31'h0, gate_out}, 0);
    drive(32'h0002_0000); check("R2 or one", {31'h0, gate_out}, 1);
    drive(32'h0004_0000); check("R2 or unmasked", {31'h0, gate_out}, 0);
    setup({10'h0, gc(1, 1, 8'h03), 20'h0}, 0, 1);
    drive(32'h0000_0000); check("R2 nor none", {31'h0, gate_out}, 1);
    setup({gc(1, 0, 8'h10), 30'h0}, 0, 1);
    drive(32'h1000_0000); check("R2 g3 or", {31'h0, gate_out}, 1);
    drive(32'h0000_0000); check("R2 g3 or none", {31'h0, gate_out}, 0);
  endtask

  task automatic t_empty();
    setup({30'h0, gc(1, 0, 8'h00)}, 0, 1);
    drive(32'h0); check("R3 and empty", {31'h0, gate_out}, 1);
    setup({30'h0, gc(1, 1, 8'h00)}, 0, 1);
    drive(32'hFFFF_FFFF); check("R3 nand empty", {31'h0, gate_out}, 0);
    setup({10'h0, gc(1, 0, 8'h00), 20'h0}, 0, 1);
    drive(32'hFFFF_FFFF); check("R3 or empty", {31'h0, gate_out}, 0);
    setup({10'h0, gc(1, 1, 8'h00), 20'h0}, 0, 1);
    drive(32'h0); check("R3 nor empty", {31'h0, gate_out}, 1);
  endtask

  task automatic t_disable();
    setup({20'h0, gc(0, 0, 8'hFF), gc(1, 0, 8'hFF)}, 0, 1);
    drive(32'h0000_00FF); check("R4 off and grp", {31'h0, gate_out}, 1);
    setup({gc(0, 1, 8'h00), gc(0, 0, 8'hFF), gc(0, 1, 8'h00), gc(1, 0, 8'hFF)}, 0, 1);
    drive(32'h0000_00FF); check("R4 off mixed", {31'h0, gate_out}, 1);
  endtask

  task automatic t_final();
    setup({10'h0, gc(1, 0, 8'h01), 10'h0, gc(1, 0, 8'h01)}, 0, 1);
    drive(32'h0001_0001); check("R5 and both", {31'h0, gate_out}, 1);
    drive(32'h0000_0001); check("R5 and one", {31'h0, gate_out}, 0);
    setup({10'h0, gc(1, 0, 8'h01), 10'h0, gc(1, 0, 8'h01)}, 1, 1);
    drive(32'h0001_0001); check("R5 nand both", {31'h0, gate_out}, 0);
    drive(32'h0000_0001); check("R5 nand one", {31'h0, gate_out}, 1);
  endtask

  task automatic t_global();
    setup({30'h0, gc(1, 0, 8'h00)}, 0, 0);
    drive(32'h0); check("R6 glob off", {31'h0, gate_out}, 0);
    setup({30'h0, gc(1, 0, 8'h01)}, 1, 0);
    drive(32'h0); check("R6 glob off inv", {31'h0, gate_out}, 0);
  endtask

  task automatic t_all_off();
    setup(40'h0, 0, 1);
    drive(32'h0); check("R7 all off zeros", {31'h0, gate_out}, 1);
    drive(32'hFFFF_FFFF); check("R7 all off ones", {31'h0, gate_out}, 1);
  endtask

  task automatic t_latch();
    setup({10'h0, gc(1, 0, 8'h01), 10'h0, gc(1, 0, 8'h01)}, 0, 1);
    drive(32'h0000_0001);
    poke(32'h0001_0000);
    check("R8 g0 reg g2 raw", {31'h0, gate_out}, 1);
    @(negedge clk);
    check("R8 after edge", {31'h0, gate_out}, 0);
    drive(32'h0001_0001);
    poke(32'h0000_0001);
    check("R8 g2 raw low", {31'h0, gate_out}, 0);
    setup({gc(1, 0, 8'h01), 30'h0}, 0, 1);
    drive(32'h0);
    poke(32'h0100_0000);
    check("R8 g3 registered", {31'h0, gate_out}, 0);
  endtask

  task automatic t_blend();
    setup({gc(1, 0, 8'h80), 30'h0}, 0, 1);
    drive(32'h8000_0000);
    poke(32'h0);
    check("R9 reg only", {31'h0, gate_out}, 1);
    @(negedge clk);
    check("R9 both low", {31'h0, gate_out}, 0);
    poke(32'h8000_0000);
    check("R9 raw only", {31'h0, gate_out}, 1);
    setup({gc(1, 0, 8'h01), 30'h0}, 0, 1);
    drive(32'h0);
    poke(32'h0100_0000);
    check("R9 bit24 not blended", {31'h0, gate_out}, 0);
  endtask

  task automatic t_monitor();
    drive(32'hA5A5_5A5A);
    check("R10 mon capture", mon_q, 32'hA5A5_5A5A);
    poke(32'h1234_5678);
    check("R10 mon holds", mon_q, 32'hA5A5_5A5A);
    @(negedge clk);
    check("R10 mon next", mon_q, 32'h1234_5678);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 300; i++) begin
      logic [39:0] cfg;
      logic [31:0] a, b;
      cfg = {$urandom, $urandom};
      a = $urandom; b = $urandom;
      setup(cfg, 1'($urandom), 1'($urandom | $urandom));
      drive(a);
      poke(b);
      check("R5 sweep", {31'h0, gate_out},
            {31'h0, model(ref_q, ctl_in, grp_cfg, comb_invert, comb_global_en)});
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_and_groups();
    t_or_groups();
    t_empty();
    t_disable();
    t_final();
    t_global();
    t_all_off();
    t_latch();
    t_blend();
    t_monitor();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule